// File: doc/BRIEF.md
# Supervisory Reset Pulse Stretcher

This block produces the reset that a microprocessor sees, from up to three request sources. The first is a digital supply-good flag from an external threshold comparator. The second is an active-low manual reset line. The third is an optional watchdog request. Reset stays asserted for as long as any request is active. Once the last request has cleared, reset stays asserted for a recovery period of `REC_CYCLES` clock cycles. The recovery timer is cleared every time a request appears and starts counting only when all requests have cleared. Every reset pulse therefore lasts at least one full recovery period, however short the event that caused it.

The supply-good flag and the manual reset line are asynchronous to the clock, so each passes through a two-flop synchronizer. The watchdog request comes from logic clocked by the same clock and is used directly. The block always drives an active-low reset. A variant parameter chooses between two builds: one also drives an active-high copy that is the exact complement of the active-low reset, and the other holds the active-high port at 0. A second parameter chooses whether the watchdog input is wired in.

Top module: `supv_reset_gen`

## Requirements
- R1: While `supply_ok_i` is 0, `rst_n_o` is 0. A fall of `supply_ok_i` before rising edge k shows at `rst_n_o` after edge k+1.
- R2: When `supply_ok_i` returns to 1 with no other request active, `rst_n_o` goes to 1 on the (REC_CYCLES+2)-th rising edge after the return, counting the first edge that samples the new value as edge 1.
- R3: A new request during the recovery period clears the timer. Reset stays asserted without a gap, and the full period of R2 or R4 is counted again from the release of the new request.
- R4: While `mr_n_i` is 0, `rst_n_o` is 0. After `mr_n_i` returns to 1, `rst_n_o` goes to 1 on the (REC_CYCLES+2)-th rising edge, counted as in R2.
- R5: A manual reset pulse that is low for a single clock cycle still yields the full recovery period of R4.
- R6: With `WD_EN`=1, a 1 on `wd_req_i` drives `rst_n_o` to 0 in the same cycle, with no synchronizer. After `wd_req_i` returns to 0, `rst_n_o` goes to 1 on the REC_CYCLES-th rising edge, counting the first edge that samples the 0 as edge 1.
- R7: With `WD_EN`=0, `wd_req_i` has no effect on either reset output.
- R8: With `VARIANT`=OUT_BOTH, `rst_o` is always the complement of `rst_n_o`. With `VARIANT`=OUT_LOW_ONLY, `rst_o` is always 0.
- R9: While `srst` is 1, `rst_n_o` is 0 and the timer is cleared. After `srst` falls with all inputs inactive, release follows the timing of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| srst | input | 1 | Synchronous power-on reset, active high |
| supply_ok_i | input | 1 | Supply-good flag from the comparator, 1 = supply above threshold (asynchronous) |
| mr_n_i | input | 1 | Manual reset request, active low (asynchronous) |
| wd_req_i | input | 1 | Watchdog reset request, active high, synchronous to `clk` |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high (complement variant) or held at 0 |

## Verification
The bench builds two instances with `REC_CYCLES`=5, which makes every recovery window short enough to count edge by edge. The first instance has the watchdog wired in and both outputs driven. The second has the watchdog removed and only the active-low output, so the same stimulus also shows R7 and the low-only side of R8. Because the period is short, the bench can sweep request widths from one to four cycles for each of the three sources. It can also inject a second request at every offset inside the recovery window and compare each measured pulse length with a count it derives from the synchronizer depth and the period.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Output variants: active-low only, or active-low plus its complement.
  typedef enum logic {
    OUT_LOW_ONLY = 1'b0,
    OUT_BOTH     = 1'b1
  } out_variant_e;

  // Number of bits needed to hold a count from 0 up to limit inclusive.
  function automatic int unsigned count_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // The recovery timer is finished once it has reached its limit.
  function automatic bit timer_finished(input int unsigned value,
                                        input int unsigned limit);
    return value >= limit;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned     WIDTH   = 2,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             srst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (srst) stage_q[s] <= RST_VAL;
        else      stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (srst) stage_q[s] <= RST_VAL;
        else      stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/supv_rec_timer.sv
module supv_rec_timer #(
  parameter int unsigned LIMIT = 10_000_000,
  localparam int unsigned CW   = supv_pkg::count_bits(LIMIT)
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          hold_i,
  output logic          done_o,
  output logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (srst || hold_i) begin
      cnt_q <= '0;
    end else if (!supv_pkg::timer_finished(32'(cnt_q), LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o  = (cnt_q == LIMIT_C);
  assign count_o = cnt_q;

  // R3: any active request leaves the timer at zero on the next cycle.
  a_r3_hold_clears: assert property (@(posedge clk) disable iff (srst)
    hold_i |=> (count_o == '0));

  // R2: once finished and with no request, the timer stays finished.
  a_r2_done_sticks: assert property (@(posedge clk) disable iff (srst)
    (done_o && !hold_i) |=> done_o);

  // R9: the power-on reset leaves the timer cleared.
  a_r9_srst_clears: assert property (@(posedge clk)
    srst |=> (count_o == '0));

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int unsigned           REC_CYCLES = 10_000_000,
  parameter int unsigned           SYNC_DEPTH = 2,
  parameter bit                    WD_EN      = 1'b1,
  parameter supv_pkg::out_variant_e VARIANT   = supv_pkg::OUT_BOTH,
  localparam int unsigned          CW         = supv_pkg::count_bits(REC_CYCLES)
) (
  input  logic clk,
  input  logic srst,
  input  logic supply_ok_i,
  input  logic mr_n_i,
  input  logic wd_req_i,
  output logic rst_n_o,
  output logic rst_o
);

  localparam logic [CW-1:0] LAST_C = CW'(REC_CYCLES - 1);

  // Synchronized view of the asynchronous requests; reset to "request active".
  logic [1:0] sync_q;
  logic       sup_ok_s;
  logic       mr_n_s;
  logic       wd_hit;
  logic       req_any;
  logic       rec_done;
  logic [CW-1:0] tmr_count;
  logic       rst_active;

  supv_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_DEPTH),
    .RST_VAL (2'b00)
  ) u_sync (
    .clk     (clk),
    .srst    (srst),
    .async_i ({supply_ok_i, mr_n_i}),
    .sync_o  (sync_q)
  );

  assign sup_ok_s = sync_q[1];
  assign mr_n_s   = sync_q[0];

  if (WD_EN) begin : g_wd
    assign wd_hit = wd_req_i;
    // R6: a watchdog request holds reset in the same cycle.
    a_r6_wd_asserts: assert property (@(posedge clk) disable iff (srst)
      wd_req_i |-> !rst_n_o);
  end else begin : g_no_wd
    assign wd_hit = 1'b0;
    // R7: with the watchdog removed, its input never keeps reset asserted.
    a_r7_wd_ignored: assert property (@(posedge clk) disable iff (srst)
      (wd_req_i && sup_ok_s && mr_n_s && rec_done) |-> rst_n_o);
  end

  assign req_any = !sup_ok_s || !mr_n_s || wd_hit;

  supv_rec_timer #(
    .LIMIT   (REC_CYCLES)
  ) u_timer (
    .clk     (clk),
    .srst    (srst),
    .hold_i  (req_any),
    .done_o  (rec_done),
    .count_o (tmr_count)
  );

  assign rst_active = req_any || !rec_done;
  assign rst_n_o    = !rst_active;

  if (VARIANT == supv_pkg::OUT_BOTH) begin : g_both
    assign rst_o = rst_active;
    // R8: the active-high output is the complement of the active-low one.
    a_r8_complement: assert property (@(posedge clk) disable iff (srst)
      rst_o != rst_n_o);
  end else begin : g_low_only
    assign rst_o = 1'b0;
    // R8: low-only variant keeps the active-high port quiet.
    a_r8_high_quiet: assert property (@(posedge clk) disable iff (srst)
      !rst_o);
  end

  // R1: a synchronized supply-low flag always holds reset.
  a_r1_supply_holds: assert property (@(posedge clk) disable iff (srst)
    !sup_ok_s |-> !rst_n_o);

  // R4: a synchronized manual request always holds reset.
  a_r4_manual_holds: assert property (@(posedge clk) disable iff (srst)
    !mr_n_s |-> !rst_n_o);

  // R5: the cycle after the last request drops, reset is still held.
  a_r5_min_width: assert property (@(posedge clk) disable iff (srst)
    $fell(req_any) |=> !rst_n_o);

  // R2: reset is released only after a quiet cycle at the last count step.
  a_r2_full_period: assert property (@(posedge clk) disable iff (srst)
    $rose(rst_n_o) |-> ($past(!req_any) && ($past(tmr_count) == LAST_C)));

endmodule

// File: tb/test_supv_reset_gen.sv
`timescale 1ns/100ps
module test_supv_reset_gen;

  localparam int unsigned REC = 5;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic sup_ok = 1'b1;
  logic mr_n = 1'b1;
  logic wd = 1'b0;
  logic rst_n_a, rst_a, rst_n_b, rst_b;

  int checks = 0;
  int errors = 0;
  bit wd_phase = 1'b0;

  always #2.5 clk = ~clk;

  supv_reset_gen #(
    .REC_CYCLES (REC),
    .WD_EN      (1'b1),
    .VARIANT    (supv_pkg::OUT_BOTH)
  ) i_supv_reset_gen (
    .clk (clk), .srst (srst), .supply_ok_i (sup_ok), .mr_n_i (mr_n),
    .wd_req_i (wd), .rst_n_o (rst_n_a), .rst_o (rst_a)
  );

  supv_reset_gen #(
    .REC_CYCLES (REC),
    .WD_EN      (1'b0),
    .VARIANT    (supv_pkg::OUT_LOW_ONLY)
  ) i_supv_reset_gen_nowd (
    .clk (clk), .srst (srst), .supply_ok_i (sup_ok), .mr_n_i (mr_n),
    .wd_req_i (wd), .rst_n_o (rst_n_b), .rst_o (rst_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse lengths worked out from the requirements: two synchronizer edges
  // plus the period for the asynchronous inputs, none for the watchdog.
  function automatic int low_samples(input int kind);
    return (kind == 2) ? int'(REC) - 1 : int'(REC) + 1;
  endfunction

  // Counts negedge samples with rst_n low after a release, then checks them.
  task automatic measure(input string req, input int exp);
    int n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wd_phase) chk(rst_n_b == 1'b1, "R7", rst_n_b, 1);
      if (rst_n_a == 1'b0) n++;
      else break;
    end
    chk(n == exp, req, n, exp);
  endtask

  task automatic drive(input int kind, input bit active);
    case (kind)
      0: sup_ok = !active;
      1: mr_n   = !active;
      default: wd = active;
    endcase
  endtask

  // R8: output relation on both builds, every cycle outside reset.
  always @(negedge clk) begin
    if (!srst) begin
      chk(rst_a == !rst_n_a, "R8", rst_a, !rst_n_a);
      chk(rst_b == 1'b0, "R8", rst_b, 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state.
    repeat (3) @(negedge clk);
    chk(rst_n_a == 1'b0, "R9", rst_n_a, 0);
    chk(rst_a == 1'b1, "R9", rst_a, 1);
    chk(rst_n_b == 1'b0, "R9", rst_n_b, 0);
    srst = 1'b0;
    measure("R9", low_samples(0));
    repeat (3) @(negedge clk);

    // R1/R2 (kind 0), R4/R5 (kind 1), R6/R7 (kind 2): width sweep.
    for (int kind = 0; kind < 3; kind++) begin
      for (int w = 1; w <= 4; w++) begin
        wd_phase = (kind == 2);
        drive(kind, 1'b1);
        repeat (w) @(negedge clk);
        if (kind == 2) begin
          chk(rst_n_a == 1'b0, "R6", rst_n_a, 0);
          chk(rst_n_b == 1'b1, "R7", rst_n_b, 1);
        end else if (w >= 2) begin
          chk(rst_n_a == 1'b0, kind == 0 ? "R1" : "R4", rst_n_a, 0);
        end
        drive(kind, 1'b0);
        if (kind == 0)      measure("R2", low_samples(0));
        else if (kind == 1) measure(w == 1 ? "R5" : "R4", low_samples(1));
        else                measure("R6", low_samples(2));
        wd_phase = 1'b0;
        repeat (3) @(negedge clk);
        chk(rst_n_a == 1'b1, "R2", rst_n_a, 1);
      end
    end

    // R3: supply drop at every offset inside a manual-reset recovery window.
    for (int off = 0; off < int'(REC); off++) begin
      mr_n = 1'b0;
      repeat (2) @(negedge clk);
      mr_n = 1'b1;
      for (int i = 0; i < off; i++) begin
        @(negedge clk);
        chk(rst_n_a == 1'b0, "R3", rst_n_a, 0);
      end
      sup_ok = 1'b0;
      @(negedge clk);
      chk(rst_n_a == 1'b0, "R3", rst_n_a, 0);
      sup_ok = 1'b1;
      measure("R3", low_samples(0));
      repeat (3) @(negedge clk);
    end

    // R3: watchdog request arriving during a supply recovery window.
    sup_ok = 1'b0;
    repeat (2) @(negedge clk);
    sup_ok = 1'b1;
    repeat (3) @(negedge clk);
    wd = 1'b1;
    @(negedge clk);
    wd = 1'b0;
    measure("R3", low_samples(2));
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule